// File: doc/BRIEF.md
# USB host channel interrupt status

This block keeps the event status of every channel of a multi-channel USB host controller. Each channel has a 14-bit sticky status word. Event strobes from the transaction engine and the DMA engine set its bits. Software clears them by writing ones through a small read/write port that selects one channel at a time. Which events may set a bit, and which set bits raise an interrupt, both depend on the DMA mode in force. In descriptor-list (scatter/gather) mode, a set of descriptor-only bits becomes live and the per-transaction bits are kept out of the interrupt. Isochronous channels never raise the descriptor-not-ready or excessive-error bits.

A small counter on each channel tracks consecutive transaction errors and sets the excessive-error bit on the third error in a row. The channels are gathered into a per-channel summary vector and into one host channel interrupt line. These are the outputs that the rest of the controller's interrupt tree uses.

Top module: `hc_chan_irq_status`

## Requirements
- R1: During reset and in the first cycle after it, every status word reads 0, and `ch_summary` and `host_ch_irq` are 0.
- R2: Each channel takes a 16-bit event field `ch_evt[16*n +: 16]`. A strobe sets the status bit one clock later. The event bits are: 0 transfer done, 1 halt / end-of-list, 2 bus error, 3 stall, 4 NAK, 5 ACK, 6 NYET, 7 CRC failure, 8 babble, 9 frame overrun, 10 toggle error, 11 descriptor not ready, 12 timeout, 13 list rollover, 14 bit-stuff error, 15 false end-of-packet. The status bits are: 0 done, 1 halted, 2 bus error, 3 stall, 4 NAK, 5 ACK, 6 NYET, 7 transaction error, 8 babble, 9 frame overrun, 10 toggle error, 11 descriptor not ready, 12 excessive errors, 13 rollover. `rd_data[31:14]` is always 0, and bits stay set until software clears them.
- R3: A write with `wr_en` clears the bits of channel `wr_ch` where `wr_data` holds a 1. Zeros, and all other channels, are left as they are. A strobe that sets a bit in the same cycle as a write that clears it wins.
- R4: Status bit 7 is set by any of the event bits 7, 12, 14 or 15.
- R5: `dma_mode` encodes 0 no DMA, 1 buffer DMA, 2 descriptor-list DMA, 3 no DMA. Bits 11, 12 and 13 can be set only in mode 2. In other modes they read as 0.
- R6: The bus error bit (2) can be set only in modes 1 and 2.
- R7: Each channel counts transaction-error events. It clears the count on event 0, 4, 5 or 6, or on `ch_restart[n]` (clearing wins). The third consecutive error sets bit 12. The count then saturates, so further errors do not set bit 12 again until the count is cleared. Bit 12 is never set on a channel whose `ch_isoc` bit is 1.
- R8: Bit 11 is never set on a channel whose `ch_isoc` bit is 1.
- R9: In mode 2, bit 1 is also set in the same cycle as a bus error, an excessive-error trip, babble (event 8) or stall (event 3). In every mode it is set by event 1.
- R10: In mode 2, status bits 3 to 10 do not contribute to `ch_summary`.
- R11: `ch_summary[n]` is the OR of channel n's readable, unmasked status bits, and `host_ch_irq` is the OR of `ch_summary`. Both follow a set or a clear one clock after the strobe or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_mode | input | 2 | DMA mode: 0/3 none, 1 buffer, 2 descriptor list |
| ch_isoc | input | NCH | Channel n is isochronous |
| ch_restart | input | NCH | Channel n re-enabled (clears the error count) |
| ch_evt | input | 16*NCH | Event strobes, 16 per channel |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_ch | input | CHW | Channel that the write addresses |
| wr_data | input | 32 | Bits to clear |
| rd_ch | input | CHW | Channel selected for reading |
| rd_data | output | 32 | Status of channel `rd_ch`, as seen in the current mode |
| ch_summary | output | NCH | Per-channel pending vector |
| host_ch_irq | output | 1 | Any channel pending |

## Verification
A strobe or a clear sampled at one rising edge shows in `rd_data`, `ch_summary` and `host_ch_irq` right after that edge. A change of `dma_mode` or `rd_ch` alters the readout and the summary at once, with no clock. The bench applies stimulus on the falling edge and advances its model at the next rising edge. It then compares all outputs at the falling edge after that, before any input moves, so the expected values always match the latency. Directed sequences cover the error-count trips, saturation and restart, the isochronous exclusions, the mode gating and a set colliding with a clear. A long run of sparse random traffic follows.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

    localparam int STW = 14;
    localparam int EVW = 16;

    typedef logic [STW-1:0] stat_t;

    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_BUF  = 2'd1,
        MODE_DESC = 2'd2,
        MODE_RSVD = 2'd3
    } dma_mode_e;

    typedef struct packed {
        logic is_desc;
        logic dma_on;
    } mode_ctl_t;

    // status bit positions
    localparam int ST_DONE   = 0;
    localparam int ST_HALT   = 1;
    localparam int ST_BUSERR = 2;
    localparam int ST_STALL  = 3;
    localparam int ST_NAK    = 4;
    localparam int ST_ACK    = 5;
    localparam int ST_NYET   = 6;
    localparam int ST_XERR   = 7;
    localparam int ST_BABBLE = 8;
    localparam int ST_FOVR   = 9;
    localparam int ST_TGL    = 10;
    localparam int ST_BNA    = 11;
    localparam int ST_XCS    = 12;
    localparam int ST_ROLL   = 13;

    // event strobe positions
    localparam int EV_DONE   = 0;
    localparam int EV_HALT   = 1;
    localparam int EV_BUSERR = 2;
    localparam int EV_STALL  = 3;
    localparam int EV_NAK    = 4;
    localparam int EV_ACK    = 5;
    localparam int EV_NYET   = 6;
    localparam int EV_CRC    = 7;
    localparam int EV_BABBLE = 8;
    localparam int EV_FOVR   = 9;
    localparam int EV_TGL    = 10;
    localparam int EV_BNA    = 11;
    localparam int EV_TMO    = 12;
    localparam int EV_ROLL   = 13;
    localparam int EV_STUFF  = 14;
    localparam int EV_EOP    = 15;

    // bits live only in descriptor mode, and per-transaction bits hidden there
    localparam stat_t DESC_ONLY = stat_t'(14'h3800);
    localparam stat_t XACT_BITS = stat_t'(14'h07F8);

    function automatic mode_ctl_t decode_mode(input dma_mode_e m);
        mode_ctl_t c;
        c.is_desc = (m == MODE_DESC);
        c.dma_on  = (m == MODE_BUF) || (m == MODE_DESC);
        return c;
    endfunction

    function automatic stat_t read_mask(input logic is_desc);
        return is_desc ? '1 : ~DESC_ONLY;
    endfunction

    function automatic stat_t irq_mask(input logic is_desc);
        return is_desc ? ~XACT_BITS : '1;
    endfunction

endpackage

// File: rtl/hcs_xerr_count.sv
module hcs_xerr_count #(
    parameter int STRIKES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic err_hit,
    input  logic good_hs,
    input  logic restart,
    output logic trip
);
    localparam int CW = $clog2(STRIKES + 1);
    localparam logic [CW-1:0] LAST = CW'(STRIKES - 1);
    localparam logic [CW-1:0] FULL = CW'(STRIKES);

    logic [CW-1:0] cnt_q;
    logic          wipe;

    assign wipe = restart | good_hs;
    assign trip = err_hit & ~wipe & (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (wipe)
            cnt_q <= '0;
        else if (err_hit && cnt_q != FULL)
            cnt_q <= cnt_q + 1'b1;
    end

    // after a trip the count sits at its ceiling
    assert_trip_saturates_R7: assert property (@(posedge clk) disable iff (rst)
        trip |=> (cnt_q == FULL));

    // a clearing event always empties the count
    assert_wipe_empties_R7: assert property (@(posedge clk) disable iff (rst)
        wipe |=> (cnt_q == '0));

endmodule

// File: rtl/hcs_chan.sv
module hcs_chan
    import hcs_pkg::*;
#(
    parameter int STRIKES = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  mode_ctl_t      ctl,
    input  logic           isoc,
    input  logic           restart,
    input  logic [EVW-1:0] evt,
    input  stat_t          clr,
    output stat_t          view,
    output logic           pend
);
    stat_t st_q;
    stat_t set_v;
    logic  xerr;
    logic  good_hs;
    logic  trip;

    assign xerr    = evt[EV_CRC] | evt[EV_TMO] | evt[EV_STUFF] | evt[EV_EOP];
    assign good_hs = evt[EV_DONE] | evt[EV_NAK] | evt[EV_ACK] | evt[EV_NYET];

    hcs_xerr_count #(.STRIKES(STRIKES)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .err_hit (xerr),
        .good_hs (good_hs),
        .restart (restart),
        .trip    (trip)
    );

    always_comb begin
        set_v             = '0;
        set_v[ST_DONE]    = evt[EV_DONE];
        set_v[ST_BUSERR]  = evt[EV_BUSERR] & ctl.dma_on;
        set_v[ST_STALL]   = evt[EV_STALL];
        set_v[ST_NAK]     = evt[EV_NAK];
        set_v[ST_ACK]     = evt[EV_ACK];
        set_v[ST_NYET]    = evt[EV_NYET];
        set_v[ST_XERR]    = xerr;
        set_v[ST_BABBLE]  = evt[EV_BABBLE];
        set_v[ST_FOVR]    = evt[EV_FOVR];
        set_v[ST_TGL]     = evt[EV_TGL];
        set_v[ST_BNA]     = evt[EV_BNA] & ctl.is_desc & ~isoc;
        set_v[ST_XCS]     = trip & ctl.is_desc & ~isoc;
        set_v[ST_ROLL]    = evt[EV_ROLL] & ctl.is_desc;
        set_v[ST_HALT]    = evt[EV_HALT] |
                            (ctl.is_desc & (set_v[ST_BUSERR] | set_v[ST_XCS] |
                                            evt[EV_BABBLE] | evt[EV_STALL]));
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= (st_q & ~clr) | set_v;
    end

    assign view = st_q & read_mask(ctl.is_desc);
    assign pend = |(view & irq_mask(ctl.is_desc));

    // bits only fall when software writes a one to them
    assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q != '0) |=> ((($past(st_q) & ~$past(clr)) & ~st_q) == '0));

    // a clear with no competing set empties those bits
    assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~set_v) != '0) |=> ((st_q & $past(clr & ~set_v)) == '0));

    // excessive-error bit cannot rise outside descriptor mode
    assert_xcs_desc_only_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(ctl.is_desc) && !$past(st_q[ST_XCS])) |-> !st_q[ST_XCS]);

    // isochronous channels never gain the descriptor-not-ready bit
    assert_isoc_bna_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(isoc) && !$past(st_q[ST_BNA])) |-> !st_q[ST_BNA]);

    // isochronous channels never gain the excessive-error bit
    assert_isoc_xcs_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(isoc) && !$past(st_q[ST_XCS])) |-> !st_q[ST_XCS]);

endmodule

// File: rtl/hc_chan_irq_status.sv
module hc_chan_irq_status
    import hcs_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int STRIKES = 3,
    localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         dma_mode,
    input  logic [NCH-1:0]     ch_isoc,
    input  logic [NCH-1:0]     ch_restart,
    input  logic [NCH*EVW-1:0] ch_evt,
    input  logic               wr_en,
    input  logic [CHW-1:0]     wr_ch,
    input  logic [31:0]        wr_data,
    input  logic [CHW-1:0]     rd_ch,
    output logic [31:0]        rd_data,
    output logic [NCH-1:0]     ch_summary,
    output logic               host_ch_irq
);
    mode_ctl_t ctl;
    stat_t     views [NCH];
    logic      unused_wr_hi;

    assign ctl          = decode_mode(dma_mode_e'(dma_mode));
    assign unused_wr_hi = ^wr_data[31:STW];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        stat_t clr_v;
        assign clr_v = (wr_en && wr_ch == CHW'(i)) ? wr_data[STW-1:0] : '0;

        hcs_chan #(.STRIKES(STRIKES)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl),
            .isoc    (ch_isoc[i]),
            .restart (ch_restart[i]),
            .evt     (ch_evt[i*EVW +: EVW]),
            .clr     (clr_v),
            .view    (views[i]),
            .pend    (ch_summary[i])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_ch == CHW'(i))
                rd_data[STW-1:0] = views[i];
        end
    end

    assign host_ch_irq = |ch_summary;

    // the line can only rise after an event strobe or a mode change
    assert_irq_cause_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(host_ch_irq) |-> ($past(|ch_evt) || ($past(dma_mode) != dma_mode)));

    // a write alone, with no events, never raises the line
    assert_irq_no_write_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (!host_ch_irq && ch_evt == '0) |=> (!host_ch_irq || ($past(dma_mode) != dma_mode)));

endmodule

// File: tb/hc_chan_irq_status_bench.sv
module hc_chan_irq_status_bench;

    localparam int NCH        = 4;
    localparam int CHW        = 2;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic [1:0]        dma_mode;
    logic [NCH-1:0]    ch_isoc;
    logic [NCH-1:0]    ch_restart;
    logic [NCH*16-1:0] ch_evt;
    logic              wr_en;
    logic [CHW-1:0]    wr_ch;
    logic [31:0]       wr_data;
    logic [CHW-1:0]    rd_ch;
    logic [31:0]       rd_data;
    logic [NCH-1:0]    ch_summary;
    logic              host_ch_irq;

    hc_chan_irq_status #(.NCH(NCH), .STRIKES(3)) u_hc_chan_irq_status (
        .clk         (clk),
        .rst         (rst),
        .dma_mode    (dma_mode),
        .ch_isoc     (ch_isoc),
        .ch_restart  (ch_restart),
        .ch_evt      (ch_evt),
        .wr_en       (wr_en),
        .wr_ch       (wr_ch),
        .wr_data     (wr_data),
        .rd_ch       (rd_ch),
        .rd_data     (rd_data),
        .ch_summary  (ch_summary),
        .host_ch_irq (host_ch_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [13:0] m_st [NCH];
    int          m_cnt [NCH];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;
    int          wrote_ch = -1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced once per rising edge
    function automatic void model_step();
        for (int c = 0; c < NCH; c++) begin
            logic [15:0] e    = ch_evt[c*16 +: 16];
            logic        desc = (dma_mode == 2'd2);
            logic        dma  = (dma_mode == 2'd1) || (dma_mode == 2'd2);
            logic        iso  = ch_isoc[c];
            logic        xe   = e[7] | e[12] | e[14] | e[15];
            logic        ok   = e[0] | e[4] | e[5] | e[6];
            logic        hit  = 1'b0;
            logic [13:0] s    = '0;
            logic [13:0] clr  = '0;
            if (ch_restart[c] || ok)
                m_cnt[c] = 0;
            else if (xe) begin
                if (m_cnt[c] == 2) hit = 1'b1;
                if (m_cnt[c] < 3) m_cnt[c] = m_cnt[c] + 1;
            end
            s[0]  = e[0];
            s[2]  = e[2] & dma;
            for (int b = 3; b <= 6; b++) s[b] = e[b];
            s[7]  = xe;
            for (int b = 8; b <= 10; b++) s[b] = e[b];
            s[11] = e[11] & desc & ~iso;
            s[12] = hit & desc & ~iso;
            s[13] = e[13] & desc;
            s[1]  = e[1] | (desc & (s[2] | s[12] | e[8] | e[3]));
            if (wr_en && int'(wr_ch) == c) clr = wr_data[13:0];
            m_st[c] = (m_st[c] & ~clr) | s;
        end
    endfunction

    task automatic compare();
        logic        desc = (dma_mode == 2'd2);
        int          rc   = int'(rd_ch);
        logic [31:0] exp  = {18'b0, m_st[rc] & (desc ? 14'h3FFF : 14'h07FF)};
        logic [31:0] es   = '0;
        check("R2 upper bits", rd_data & 32'hFFFF_C000, 32'h0);
        check("R2 plain bits", rd_data & 32'h0779, exp & 32'h0779);
        check("R9 halted bit", rd_data & 32'h0002, exp & 32'h0002);
        check("R6 bus error bit", rd_data & 32'h0004, exp & 32'h0004);
        check("R4 transaction error bit", rd_data & 32'h0080, exp & 32'h0080);
        check("R8 R5 not-ready bit", rd_data & 32'h0800, exp & 32'h0800);
        check("R7 excessive error bit", rd_data & 32'h1000, exp & 32'h1000);
        check("R5 rollover bit", rd_data & 32'h2000, exp & 32'h2000);
        if (wrote_ch == rc) check("R3 word after clear", rd_data, exp);
        for (int c = 0; c < NCH; c++) begin
            logic [13:0] v = m_st[c] & (desc ? 14'h3FFF : 14'h07FF);
            es[c] = |(v & (desc ? 14'h3807 : 14'h3FFF));
        end
        check(desc ? "R10 summary" : "R11 summary", {28'b0, ch_summary}, es);
        check("R11 host irq", {31'b0, host_ch_irq}, {31'b0, |es[NCH-1:0]});
    endtask

    // apply current inputs for one clock, then compare at the falling edge
    task automatic tick(input int rsel);
        rd_ch    = CHW'(rsel);
        wrote_ch = wr_en ? int'(wr_ch) : -1;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        ch_evt     = '0;
        ch_restart = '0;
        wr_en      = 1'b0;
        wr_data    = '0;
    endtask

    task automatic ev(input int ch, input int b);
        ch_evt[ch*16 + b] = 1'b1;
    endtask

    task automatic wclr(input int ch, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_ch   = CHW'(ch);
        wr_data = d;
    endtask

    task automatic summary_and_end();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            summary_and_end();
        end
    end

    initial begin
        rst = 1'b1; dma_mode = 2'd0; ch_isoc = '0; ch_restart = '0; ch_evt = '0;
        wr_en = 1'b0; wr_ch = '0; wr_data = '0; rd_ch = '0;
        for (int c = 0; c < NCH; c++) begin m_st[c] = '0; m_cnt[c] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int c = 0; c < NCH; c++) begin
            rd_ch = CHW'(c);
            #1;
            check("R1 reset status", rd_data, 32'h0);
        end
        check("R1 reset summary", {28'b0, ch_summary}, 32'h0);
        check("R1 reset irq", {31'b0, host_ch_irq}, 32'h0);
        rst = 1'b0;
        tick(0);
        check("R1 first cycle irq", {31'b0, host_ch_irq}, 32'h0);

        // R4 R7 R9: three errors on ch0 in descriptor mode
        dma_mode = 2'd2;
        ev(0, 7);  tick(0);
        ev(0, 12); tick(0);
        ev(0, 14); tick(0);
        check("R7 trip on third error", rd_data & 32'h1002, 32'h1002);
        wclr(0, 32'hFFFF_FFFF); tick(0);
        check("R3 all cleared", rd_data, 32'h0);
        ev(0, 15); tick(0);
        check("R7 saturated, no retrip", rd_data & 32'h1000, 32'h0);
        ev(0, 5); tick(0);
        ev(0, 7); tick(0);
        ev(0, 7); tick(0);
        ev(0, 15); tick(0);
        check("R7 retrip after ACK", rd_data & 32'h1000, 32'h1000);
        // restart mid-count
        wclr(0, 32'h3FFF); tick(0);
        ev(0, 7); tick(0);
        ev(0, 7); ch_restart[0] = 1'b1; tick(0);
        ev(0, 7); tick(0);
        ev(0, 7); tick(0);
        check("R7 restart empties count", rd_data & 32'h1000, 32'h0);

        // R8 R7: isochronous channel 1
        ch_isoc = 4'b0010;
        ev(1, 7); tick(1);
        ev(1, 7); tick(1);
        ev(1, 7); ev(1, 11); ev(1, 13); tick(1);
        check("R8 isoc no not-ready/excess", rd_data & 32'h3800, 32'h2000);
        ch_isoc = '0;

        // R5 R6: no-DMA mode on ch2
        dma_mode = 2'd0;
        ev(2, 11); ev(2, 13); ev(2, 2); tick(2);
        check("R6 bus error ignored without DMA", rd_data & 32'h0004, 32'h0);
        check("R5 desc bits ignored without DMA", rd_data & 32'h3800, 32'h0);
        dma_mode = 2'd1;
        ev(2, 2); tick(2);
        check("R6 bus error in buffer DMA", rd_data & 32'h0006, 32'h0004);

        // R3: set wins over clear, zero write no effect
        ev(3, 3); wclr(3, 32'h0000_0008); tick(3);
        check("R3 set beats clear", rd_data & 32'h0008, 32'h0008);
        wclr(3, 32'h0); tick(3);
        check("R3 zero write ignored", rd_data & 32'h0008, 32'h0008);
        wclr(2, 32'h3FFF); tick(3);
        check("R3 other channel untouched", rd_data & 32'h0008, 32'h0008);

        // R10: stall alone is masked in descriptor mode
        dma_mode = 2'd2;
        tick(3);
        check("R10 stall masked from summary", {31'b0, ch_summary[3]}, 32'h0);
        dma_mode = 2'd0;
        tick(3);
        check("R11 stall visible outside descriptor mode", {31'b0, ch_summary[3]}, 32'h1);

        // clean slate, then sparse random traffic
        for (int c = 0; c < NCH; c++) begin wclr(c, 32'h3FFF); tick(c); end
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 64 == 0) dma_mode = 2'($urandom % 4);
            if ($urandom % 64 == 0) ch_isoc = NCH'($urandom);
            for (int c = 0; c < NCH; c++) begin
                for (int b = 0; b < 16; b++) begin
                    int lim = (b == 0 || b == 4 || b == 5 || b == 6) ? 40 : 12;
                    if ($urandom % lim == 0) ev(c, b);
                end
                if ($urandom % 50 == 0) ch_restart[c] = 1'b1;
            end
            if ($urandom % 4 == 0) wclr(int'($urandom % NCH), $urandom & $urandom);
            tick(n % NCH);
        end
        summary_and_end();
    end

endmodule